// File: doc/BRIEF.md
# Serial Audio Link Input Frame Receiver

This block is the receiving half of a controller attached to a time-slotted serial audio link. The controller drives its own frame marker (`sync`) on rising edges of the bit clock. The receiver watches that marker and samples the incoming serial data line on falling edges. Each 256-bit frame is split into three parts: the codec-ready flag, twelve per-slot valid tags, and twelve 20-bit slot words.

Frame timing works as follows. A low-to-high change of `sync` is seen on the falling edge that follows the rising edge that raised it, and that falling edge marks the frame start. The codec puts the first frame bit on the line at the next rising edge, and the receiver samples it on the falling edge after that. The frame then runs as a 16-bit tag slot followed by twelve 20-bit data slots. Slot words leave the block in parallel, each with a one-cycle strobe and its slot number. A frame-done pulse marks the final bit. Every new `sync` rise realigns the bit position, so a frame cut short by an early marker is dropped at the point where the new frame begins.

All logic runs on the falling edge of `bit_clk`. Reset is synchronous and active low.

Top module: `aclink_frame_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, all outputs are 0 until the first frame is received: `codec_ready`, `slot_valid`, `tag_strobe`, `slot_data`, `slot_idx`, `slot_strobe` and `frame_done`.
- R2: Before the first `sync` rise after reset, no serial data is captured and no strobe fires. After a rise, the bit driven on the next rising edge is frame position 0.
- R3: `codec_ready` takes the value of frame position 0, which is tag bit 15.
- R4: `slot_valid[k-1]` takes the value of frame position k for k = 1..12, which is tag bits 14 down to 3. Positions 13 to 15 are ignored. `codec_ready` and `slot_valid` update together with a one-cycle `tag_strobe` on the falling edge that captures position 15, and hold until the next frame's update.
- R5: Slot k (k = 1..12) covers positions 16+20(k-1) to 16+20k-1, received MSB first. On the falling edge that captures its last bit, `slot_data` shows the word, `slot_idx` shows k, and `slot_strobe` pulses for one cycle. `slot_data` and `slot_idx` hold until the next strobe.
- R6: `frame_done` pulses for one cycle on the falling edge that captures position 255, which is the same cycle as the slot 12 strobe.
- R7: Every `sync` rise restarts the frame at position 0, even in the middle of a frame. In that case the bit sampled on the rise edge still counts as the last bit of the old frame. Slots the old frame did not complete are never strobed, and it raises no `frame_done`.
- R8: After position 255, capture stops until the next `sync` rise, and no further strobes fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Frame marker driven by the controller on rising edges |
| sdata_in | input | 1 | Serial data from the codec |
| codec_ready | output | 1 | Codec-ready flag of the last received tag slot |
| slot_valid | output | 12 | Valid tags; bit k-1 belongs to slot k |
| tag_strobe | output | 1 | One-cycle pulse when the tag outputs update |
| slot_data | output | 20 | Last completed slot word |
| slot_idx | output | 4 | Slot number (1..12) of `slot_data` |
| slot_strobe | output | 1 | One-cycle pulse when a slot word completes |
| frame_done | output | 1 | One-cycle pulse when position 255 is captured |

## Verification
The bench feeds full frames with four kinds of content:
- All slots tagged valid, with random words.
- A sparse valid pattern with alternating all-ones and all-zeros words. This separates the bit order and slot boundaries from simple level errors.
- No valid tags, with walking-one words. A single shifted or misplaced bit is visible at once.
- Random data again, closing the run.

Two further patterns test the framing. One frame is cut short at 100 bits by an early marker, which checks that only the slots it completed are reported and that counting restarts. Random serial data is also sent before any marker and after the final frame, which checks that nothing is captured outside a framed window.

// File: rtl/aclink_rx_pkg.sv
// Shared frame geometry for the serial link input receiver.
// Assumes the tag slot is longer than the number of data slots plus one.
package aclink_rx_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;
    localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * DATA_SLOTS;
endpackage

// File: rtl/aclink_rx_sequencer.sv
// Frame position tracker. Detects the rise of the controller's frame marker
// on the falling edge and keeps the position of the bit being sampled: the
// slot number (0 = tag slot) and the bit within that slot.
// Assumes: sync changes on rising edges, so it is stable at falling edges.
module aclink_rx_sequencer #(
    parameter int TAG_BITS   = aclink_rx_pkg::TAG_BITS,
    parameter int SLOT_BITS  = aclink_rx_pkg::SLOT_BITS,
    parameter int DATA_SLOTS = aclink_rx_pkg::DATA_SLOTS,
    localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * DATA_SLOTS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int IDX_W      = $clog2(DATA_SLOTS + 1),
    localparam int BIS_W      = $clog2((TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             cap_en,
    output logic [IDX_W-1:0] slot_num,
    output logic [BIS_W-1:0] bit_in_slot,
    output logic             tag_last,
    output logic             slot_last,
    output logic             frame_last
);
    logic             sync_q;
    logic             armed;
    logic [POS_W-1:0] pos_q;
    logic [IDX_W-1:0] slot_q;
    logic [BIS_W-1:0] bis_q;
    logic             sync_rise;

    // Decode of the current bit position for the capture logic
    always_comb begin
        sync_rise   = sync & ~sync_q;
        cap_en      = armed;
        slot_num    = slot_q;
        bit_in_slot = bis_q;
        tag_last    = armed && (slot_q == '0) && (bis_q == BIS_W'(TAG_BITS - 1));
        slot_last   = armed && (slot_q != '0) && (bis_q == BIS_W'(SLOT_BITS - 1));
        frame_last  = armed && (pos_q == POS_W'(FRAME_BITS - 1));
    end

    // Position counters; a marker rise realigns them, the last bit disarms
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            armed  <= 1'b0;
            pos_q  <= '0;
            slot_q <= '0;
            bis_q  <= '0;
        end else begin
            sync_q <= sync;
            if (sync_rise) begin
                armed  <= 1'b1;
                pos_q  <= '0;
                slot_q <= '0;
                bis_q  <= '0;
            end else if (armed) begin
                if (frame_last) begin
                    armed <= 1'b0;
                end
                pos_q <= pos_q + POS_W'(1);
                if (tag_last || slot_last) begin
                    slot_q <= slot_q + IDX_W'(1);
                    bis_q  <= '0;
                end else begin
                    bis_q <= bis_q + BIS_W'(1);
                end
            end
        end
    end

    // R7
    realign_chk: assert property (@(negedge clk) disable iff (!rst_n)
        sync_rise |=> (cap_en && slot_num == '0 && bit_in_slot == '0))
        else $error("frame marker rise did not restart the position");

    // R8
    stop_after_last_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (frame_last && !sync_rise) |=> !cap_en)
        else $error("capture continued past the last frame bit");
endmodule

// File: rtl/aclink_rx_tag_capture.sv
// Tag slot capture. Stores the codec-ready flag (position 0) and the valid
// flags for slots 1..DATA_SLOTS (positions 1..DATA_SLOTS), ignores the rest
// of the tag slot, and publishes all flags at once when the tag slot ends.
// Assumes DATA_SLOTS < TAG_BITS - 1.
module aclink_rx_tag_capture #(
    parameter int TAG_BITS   = aclink_rx_pkg::TAG_BITS,
    parameter int DATA_SLOTS = aclink_rx_pkg::DATA_SLOTS,
    parameter int BIS_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_tag,
    input  logic                  tag_last,
    input  logic [BIS_W-1:0]      bit_in_slot,
    input  logic                  sdata,
    output logic                  codec_ready,
    output logic [DATA_SLOTS-1:0] slot_valid,
    output logic                  tag_strobe
);
    logic [DATA_SLOTS:0] pending;

    // Collect tag bits by position while the tag slot is being received
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (in_tag) begin
            for (int k = 0; k <= DATA_SLOTS; k++) begin
                if (bit_in_slot == BIS_W'(k)) begin
                    pending[k] <= sdata;
                end
            end
        end
    end

    // Publish the collected flags at the end of the tag slot
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            codec_ready <= 1'b0;
            slot_valid  <= '0;
            tag_strobe  <= 1'b0;
        end else begin
            tag_strobe <= tag_last;
            if (tag_last) begin
                codec_ready <= pending[0];
                slot_valid  <= pending[DATA_SLOTS:1];
            end
        end
    end

    // R4
    tag_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !tag_strobe |-> ($stable(slot_valid) && $stable(codec_ready)))
        else $error("tag outputs changed without a tag strobe");
endmodule

// File: rtl/aclink_rx_slot_shifter.sv
// Data slot deserializer. Shifts slot bits in MSB first and presents the
// full word with its slot number and a one-cycle strobe when the slot's
// last bit arrives.
// Assumes the shift enable is high for exactly SLOT_BITS bits per slot.
module aclink_rx_slot_shifter #(
    parameter int SLOT_BITS = aclink_rx_pkg::SLOT_BITS,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 slot_last,
    input  logic [IDX_W-1:0]     slot_num,
    input  logic                 sdata,
    output logic [SLOT_BITS-1:0] slot_data,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 slot_strobe
);
    logic [SLOT_BITS-2:0] shreg;

    // Shift the leading bits of the slot
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[SLOT_BITS-3:0], sdata};
        end
    end

    // Present the finished word with its slot number
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            slot_data   <= '0;
            slot_idx    <= '0;
            slot_strobe <= 1'b0;
        end else begin
            slot_strobe <= slot_last;
            if (slot_last) begin
                slot_data <= {shreg, sdata};
                slot_idx  <= slot_num;
            end
        end
    end

    // R5
    strobe_needs_capture_chk: assert property (@(negedge clk) disable iff (!rst_n)
        slot_strobe |-> $past(shift_en))
        else $error("slot strobe without a captured bit");

    // R5
    word_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !slot_strobe |-> ($stable(slot_data) && $stable(slot_idx)))
        else $error("slot word changed without a strobe");
endmodule

// File: rtl/aclink_frame_rx.sv
// Input frame receiver for a slotted serial audio link, on the controller
// side. Uses the controller's own frame marker to find frame start, samples
// data on the falling edge and splits each frame into the ready flag, the
// valid tags and the slot words.
// Assumes sync and sdata_in change only on rising edges of bit_clk.
module aclink_frame_rx #(
    parameter int TAG_BITS   = aclink_rx_pkg::TAG_BITS,
    parameter int SLOT_BITS  = aclink_rx_pkg::SLOT_BITS,
    parameter int DATA_SLOTS = aclink_rx_pkg::DATA_SLOTS
) (
    input  logic                               bit_clk,
    input  logic                               rst_n,
    input  logic                               sync,
    input  logic                               sdata_in,
    output logic                               codec_ready,
    output logic [DATA_SLOTS-1:0]              slot_valid,
    output logic                               tag_strobe,
    output logic [SLOT_BITS-1:0]               slot_data,
    output logic [$clog2(DATA_SLOTS + 1)-1:0]  slot_idx,
    output logic                               slot_strobe,
    output logic                               frame_done
);
    localparam int IDX_W = $clog2(DATA_SLOTS + 1);
    localparam int BIS_W = $clog2((TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS);

    logic             cap_en;
    logic [IDX_W-1:0] slot_num;
    logic [BIS_W-1:0] bit_in_slot;
    logic             tag_last;
    logic             slot_last;
    logic             frame_last;
    logic             in_tag;
    logic             in_data;

    aclink_rx_sequencer #(
        .TAG_BITS   (TAG_BITS),
        .SLOT_BITS  (SLOT_BITS),
        .DATA_SLOTS (DATA_SLOTS)
    ) i_seq (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .cap_en      (cap_en),
        .slot_num    (slot_num),
        .bit_in_slot (bit_in_slot),
        .tag_last    (tag_last),
        .slot_last   (slot_last),
        .frame_last  (frame_last)
    );

    // Route each sampled bit to the tag or data capture
    always_comb begin
        in_tag  = cap_en && (slot_num == '0);
        in_data = cap_en && (slot_num != '0);
    end

    aclink_rx_tag_capture #(
        .TAG_BITS   (TAG_BITS),
        .DATA_SLOTS (DATA_SLOTS),
        .BIS_W      (BIS_W)
    ) i_tag (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .in_tag      (in_tag),
        .tag_last    (tag_last),
        .bit_in_slot (bit_in_slot),
        .sdata       (sdata_in),
        .codec_ready (codec_ready),
        .slot_valid  (slot_valid),
        .tag_strobe  (tag_strobe)
    );

    aclink_rx_slot_shifter #(
        .SLOT_BITS (SLOT_BITS),
        .IDX_W     (IDX_W)
    ) i_slot (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .shift_en    (in_data),
        .slot_last   (slot_last),
        .slot_num    (slot_num),
        .sdata       (sdata_in),
        .slot_data   (slot_data),
        .slot_idx    (slot_idx),
        .slot_strobe (slot_strobe)
    );

    // Frame-done pulse on the capture of the last frame bit
    always_ff @(negedge bit_clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_last;
        end
    end

    // R6
    done_with_last_slot_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_done |-> (slot_strobe && slot_idx == IDX_W'(DATA_SLOTS)))
        else $error("frame done without the last slot word");
endmodule

// File: tb/test_aclink_frame_rx.sv
// Scoreboard bench: frame driver tasks push expected events into a queue,
// a monitor pops and compares them as the receiver strobes its outputs.
module test_aclink_frame_rx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        sdata = 1'b0;
    logic        codec_ready;
    logic [11:0] slot_valid;
    logic        tag_strobe;
    logic [19:0] slot_data;
    logic [3:0]  slot_idx;
    logic        slot_strobe;
    logic        frame_done;

    int check_cnt = 0;
    int fail_cnt  = 0;
    int evt_cnt   = 0;
    bit finished  = 1'b0;

    int          qk[$];
    logic [31:0] qv[$];
    string       qr[$];

    logic        fb [256];
    logic [19:0] sw [12];
    logic        cur_cr;
    logic [11:0] cur_vld;
    logic        last_bit = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aclink_frame_rx i_aclink_frame_rx (
        .bit_clk     (clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .sdata_in    (sdata),
        .codec_ready (codec_ready),
        .slot_valid  (slot_valid),
        .tag_strobe  (tag_strobe),
        .slot_data   (slot_data),
        .slot_idx    (slot_idx),
        .slot_strobe (slot_strobe),
        .frame_done  (frame_done)
    );

    task automatic check_eq(input string req, input logic [31:0] got, input logic [31:0] exp);
        check_cnt++;
        if (got !== exp) begin
            fail_cnt++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_evt(input int kind, input logic [31:0] got);
        check_cnt++;
        if (qk.size() == 0) begin
            fail_cnt++;
            $display("FAIL R2 R8: unexpected event kind %0d value %h, expected none", kind, got);
        end else begin
            int          ek = qk.pop_front();
            logic [31:0] ev = qv.pop_front();
            string       er = qr.pop_front();
            if (ek != kind || ev !== got) begin
                fail_cnt++;
                $display("FAIL %s: got kind %0d value %h expected kind %0d value %h",
                         er, kind, got, ek, ev);
            end
        end
    endtask

    // Monitor: compare every strobe against the head of the queue
    always @(posedge clk) begin
        if (rst_n) begin
            if (tag_strobe) begin
                evt_cnt++;
                check_evt(0, {19'd0, codec_ready, slot_valid});
            end
            if (slot_strobe) begin
                evt_cnt++;
                check_evt(1, {8'd0, slot_idx, slot_data});
            end
            if (frame_done) begin
                evt_cnt++;
                check_evt(2, 32'd0);
            end
        end
    end

    // Build frame content; pattern 0 random, 1 alternating ones/zeros, 2 walking one
    task automatic load_frame(input logic cr, input logic [11:0] vld, input int pattern);
        cur_cr  = cr;
        cur_vld = vld;
        for (int k = 0; k < 12; k++) begin
            case (pattern)
                1:       sw[k] = k[0] ? 20'h00000 : 20'hFFFFF;
                2:       sw[k] = 20'h1 << (k + 4);
                default: sw[k] = 20'($urandom);
            endcase
        end
        fb[0] = cr;
        for (int k = 1; k <= 12; k++) fb[k] = vld[k-1];
        for (int k = 13; k < 16; k++) fb[k] = 1'b0;
        for (int k = 0; k < 12; k++) begin
            for (int b = 0; b < 20; b++) fb[16 + 20*k + b] = sw[k][19-b];
        end
    endtask

    // Drive n bit periods of the loaded frame, pushing what should appear
    task automatic play(input int n);
        if (n >= 16) begin
            qk.push_back(0); qv.push_back({19'd0, cur_cr, cur_vld});
            qr.push_back(n == 256 ? "R2 R3 R4" : "R7");
        end
        for (int k = 1; k <= 12; k++) begin
            if (n >= 16 + 20*k) begin
                qk.push_back(1); qv.push_back({8'd0, 4'(k), sw[k-1]});
                qr.push_back(n == 256 ? "R5" : "R7");
            end
        end
        if (n == 256) begin
            qk.push_back(2); qv.push_back(32'd0); qr.push_back("R6");
        end
        for (int j = 0; j < n; j++) begin
            @(posedge clk); #1;
            sync  = (j < 16);
            sdata = (j == 0) ? last_bit : fb[j-1];
        end
        last_bit = fb[n-1];
    endtask

    task automatic idle_random(input int cycles);
        for (int j = 0; j < cycles; j++) begin
            @(posedge clk); #1;
            sync  = 1'b0;
            sdata = 1'($urandom);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", check_cnt, fail_cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fail_cnt++;
            $display("FAIL watchdog: got timeout expected run completion");
            summary();
            $finish;
        end
    end

    initial begin
        int saved;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check_eq("R1", {19'd0, codec_ready, slot_valid}, 32'd0);
        check_eq("R1", {8'd0, slot_idx, slot_data}, 32'd0);
        check_eq("R1", {29'd0, tag_strobe, slot_strobe, frame_done}, 32'd0);

        // R2 no capture before any marker rise
        idle_random(300);
        check_eq("R2", evt_cnt, 0);

        load_frame(1'b1, 12'hFFF, 0);
        play(256);
        load_frame(1'b0, 12'b1010_0101_0011, 1);
        play(256);
        // R7 early marker after 100 bits: tag and slots 1..4 only
        load_frame(1'b1, 12'h5A3, 0);
        play(100);
        load_frame(1'b1, 12'h000, 2);
        play(256);
        load_frame(1'b0, 12'h801, 0);
        play(256);

        // final bit of the last frame, then let strobes drain
        @(posedge clk); #1;
        sync  = 1'b0;
        sdata = last_bit;
        repeat (5) @(posedge clk);
        check_eq("R6", qk.size(), 0);

        // R8 nothing captured after the last bit without a new rise
        saved = evt_cnt;
        idle_random(300);
        check_eq("R8", evt_cnt, saved);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule